// File: doc/BRIEF.md
# Pseudorandom Self-Test Engine with Parallel Signature Compression

The block tests a small combinational circuit on chip without an external tester. A start strobe loads a pseudorandom generator from a programmable seed. The generator then supplies one input vector per clock cycle to the circuit under test, for a programmed number of cycles. Each output vector of the circuit is folded in parallel into a multi-input signature register. The register XORs every circuit output into its own stage along with the shift feedback.

After the last vector there is one settle cycle. The engine then compares the accumulated signature with an expected constant, which is the signature a fault-free circuit produces. The engine raises `done` and reports the outcome on `pass`. When no test is running, the circuit under test takes its inputs from the functional input pins instead of the generator, and its outputs stay visible on `cut_out`.

The included circuit under test is a 4-input, 4-output example. Control and status pins are plain levels and strobes. The functional path is purely combinational and has no handshake, so there is no back-pressure anywhere in the block.

Top module: `bist_engine`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted start, `busy`, `done` and `pass` are 0.
- R2: A start is accepted on a rising clock edge where `start` is 1 and `busy` is 0. The edge clears `done`, and `busy` is 1 from the next cycle on. A start seen while `busy` is 1 is ignored, together with the `seed` and `pat_count` values present at that moment.
- R3: After an accepted start, `busy` stays high for exactly `pat_count` + 1 cycles: `pat_count` pattern cycles followed by one settle cycle. A count of 0 gives a single busy cycle.
- R4: The generator loads the seed at an accepted start. At the end of each pattern cycle it steps from s to {^(s & GEN_TAPS), s[3:1]}. The default GEN_TAPS is 4'b1001, so the new top bit is s[3] XOR s[0] and the other bits shift right by one.
- R5: A seed of 0000 is loaded as 0001, so the generator never holds zero.
- R6: The signature register is cleared to zero at an accepted start. In each pattern cycle, with circuit output P, stage i below the top loads sig[i+1] XOR P[i], and stage 3 loads ^(sig & SIG_TAPS) XOR P[3]. The default SIG_TAPS is 4'b1001.
- R7: `done` rises as `busy` falls and stays high until the next accepted start. At that point `pass` is 1 exactly when the signature equals `expect_sig`. `pass` is 0 whenever `done` is 0.
- R8: During pattern cycles the circuit under test sees the generator state. In all other cycles it sees `func_in`. `cut_out` always shows the circuit outputs.
- R9: With inputs a=in[0], b=in[1], c=in[2], d=in[3], the example circuit gives out[0]=(a&b)|c, out[1]=a^b^c^d, out[2]=~(b|d) and out[3]=(a&c)^d.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, honoured only when idle |
| seed | input | 4 | Generator seed, sampled at start |
| pat_count | input | CNT_W | Number of pattern cycles, sampled at start |
| expect_sig | input | 4 | Fault-free signature, sampled in the settle cycle |
| func_in | input | 4 | Functional inputs of the circuit under test |
| cut_out | output | 4 | Outputs of the circuit under test |
| busy | output | 1 | Test run in progress |
| done | output | 1 | Run finished, result valid |
| pass | output | 1 | Signature matched (valid with done) |

## Verification
The bench builds the engine with its defaults: CNT_W = 8 and both tap masks at 4'b1001. At these settings the generator has a period of 15. Runs of 30 and 255 patterns therefore wrap the sequence many times, and the full width of the pattern counter is used, including the zero-count case. The 4-bit signature is small enough that the bench can fold the reference signature itself for every seed. This also makes it possible to show that a single flipped bit of the expected value turns the result to fail.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int VEC_W = 4;
  localparam int SIG_W = 4;
  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [SIG_W-1:0] sig_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SETTLE, ST_DONE} bist_state_e;
endpackage

// File: rtl/bist_patgen.sv
module bist_patgen #(
  parameter int W = 4,
  parameter logic [W-1:0] TAPS = 4'b1001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] vec
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] seed_fix;

  // zero seed would lock the register: substitute 0..01
  assign seed_fix = (seed == '0) ? ONE : seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vec <= ONE;
    else if (load) vec <= seed_fix;
    else if (step) vec <= {^(vec & TAPS), vec[W-1:1]};
  end

  // R5: generator never reaches the all-zero lock-up state
  assert_gen_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n) vec != '0);
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int W = 4,
  parameter logic [W-1:0] TAPS = 4'b1001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] resp,
  output logic [W-1:0] sig
);
  logic [W-1:0] nxt;

  generate
    for (genvar i = 0; i < W; i++) begin : g_stage
      if (i == W - 1) begin : g_top
        assign nxt[i] = (^(sig & TAPS)) ^ resp[i];
      end else begin : g_mid
        assign nxt[i] = sig[i+1] ^ resp[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sig <= '0;
    else if (clr)  sig <= '0;
    else if (en)   sig <= nxt;
  end

  // R6: a clear request empties the signature on the following cycle
  assert_sig_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n) clr |=> sig == '0);
endmodule

// File: rtl/bist_cut.sv
module bist_cut (
  input  logic [3:0] in_vec,
  output logic [3:0] out_vec
);
  logic a, b, c, d;
  assign a = in_vec[0];
  assign b = in_vec[1];
  assign c = in_vec[2];
  assign d = in_vec[3];

  assign out_vec[0] = (a & b) | c;
  assign out_vec[1] = a ^ b ^ c ^ d;
  assign out_vec[2] = ~(b | d);
  assign out_vec[3] = (a & c) ^ d;
endmodule

// File: rtl/bist_engine.sv
module bist_engine
  import bist_pkg::*;
#(
  parameter int   CNT_W    = 8,
  parameter vec_t GEN_TAPS = 4'b1001,
  parameter sig_t SIG_TAPS = 4'b1001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VEC_W-1:0] seed,
  input  logic [CNT_W-1:0] pat_count,
  input  logic [SIG_W-1:0] expect_sig,
  input  logic [VEC_W-1:0] func_in,
  output logic [SIG_W-1:0] cut_out,
  output logic             busy,
  output logic             done,
  output logic             pass
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  bist_state_e      state;
  logic [CNT_W-1:0] remain;
  logic             match;
  logic             accept, test_mode;
  vec_t             gen_vec, cut_in;
  sig_t             sig;

  assign accept    = start && (state == ST_IDLE || state == ST_DONE);
  assign test_mode = (state == ST_RUN);
  assign cut_in    = test_mode ? gen_vec : func_in;

  bist_patgen #(.W(VEC_W), .TAPS(GEN_TAPS)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(accept), .seed(seed),
    .step(test_mode), .vec(gen_vec)
  );

  bist_cut u_cut (.in_vec(cut_in), .out_vec(cut_out));

  bist_misr #(.W(SIG_W), .TAPS(SIG_TAPS)) u_misr (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(test_mode),
    .resp(cut_out), .sig(sig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
      match  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (accept) begin
          remain <= pat_count;
          match  <= 1'b0;
          state  <= (pat_count == '0) ? ST_SETTLE : ST_RUN;
        end
        ST_RUN: begin
          remain <= remain - CNT_ONE;
          if (remain == CNT_ONE) state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          match <= (sig == expect_sig);
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN) || (state == ST_SETTLE);
  assign done = (state == ST_DONE);
  assign pass = done && match;

  // run-length monitor for R3
  logic [CNT_W:0] busy_len;
  logic [CNT_W:0] len_goal;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= '0;
      len_goal <= '0;
    end else if (accept) begin
      busy_len <= '0;
      len_goal <= {1'b0, pat_count} + 1'b1;
    end else if (busy) begin
      busy_len <= busy_len + 1'b1;
    end
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == len_goal);
  assert_pass_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_start_opens_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
endmodule

// File: tb/test_bist_engine.sv
module test_bist_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] seed = '0;
  logic [7:0] pat_count = '0;
  logic [3:0] expect_sig = '0;
  logic [3:0] func_in = '0;
  logic [3:0] cut_out;
  logic       busy, done, pass;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  bist_engine i_bist_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .pat_count(pat_count),
    .expect_sig(expect_sig), .func_in(func_in), .cut_out(cut_out),
    .busy(busy), .done(done), .pass(pass)
  );

  function automatic logic [3:0] cut_model(input logic [3:0] v);  // R9
    logic a, b, c, d;
    {d, c, b, a} = v;
    return {(a & c) ^ d, ~(b | d), a ^ b ^ c ^ d, (a & b) | c};
  endfunction

  function automatic logic [3:0] fix_seed(input logic [3:0] s);  // R5
    return (s == 4'h0) ? 4'h1 : s;
  endfunction

  function automatic logic [3:0] sig_model(input logic [3:0] sd, input int n);  // R4, R6
    logic [3:0] g, m, p;
    g = fix_seed(sd);
    m = 4'h0;
    for (int k = 0; k < n; k++) begin
      p = cut_model(g);
      m = {m[3] ^ m[0] ^ p[3], m[3] ^ p[2], m[2] ^ p[1], m[1] ^ p[0]};
      g = {g[3] ^ g[0], g[3:1]};
    end
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // poke_at >= 0: pulse start (with other seed/count) at that busy cycle
  task automatic run(input logic [3:0] sd, input int n, input logic [3:0] esig,
                     input bit epass, input int poke_at);
    int len;
    @(negedge clk);
    seed = sd; pat_count = n[7:0]; expect_sig = esig; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R2 busy after start", {busy, done}, 2'b10);
    if (n > 0) check(cut_out == cut_model(fix_seed(sd)), "R8 first vector from generator",
                     cut_out, cut_model(fix_seed(sd)));
    len = 0;
    while (busy && len < 1000) begin
      len++;
      if (len == poke_at) begin
        start = 1'b1; seed = 4'h3; pat_count = 8'd0;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(len == n + 1, "R3 busy length", len, n + 1);
    check(done == 1'b1, "R7 done after run", done, 1);
    check(pass == epass, "R7 pass result", pass, epass);
  endtask

  localparam int NVEC = 6;
  localparam logic [11:0] VECS [NVEC] = '{
    {4'h1, 8'd1}, {4'h8, 8'd15}, {4'h0, 8'd7},
    {4'hA, 8'd30}, {4'hF, 8'd4}, {4'h6, 8'd255}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] s;
    repeat (3) @(negedge clk);
    check({busy, done, pass} == 3'b000, "R1 in reset", {busy, done, pass}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, pass} == 3'b000, "R1 after reset", {busy, done, pass}, 0);

    for (int v = 0; v < 16; v += 5) begin  // R8 idle mux, R9 function
      func_in = v[3:0];
      #1;
      check(cut_out == cut_model(v[3:0]), "R9 functional path", cut_out, cut_model(v[3:0]));
    end

    for (int i = 0; i < NVEC; i++) begin  // R4 R6 R7 table walk
      s = VECS[i][11:8];
      run(s, int'(VECS[i][7:0]), sig_model(s, int'(VECS[i][7:0])), 1'b1, -1);
    end

    run(4'h5, 9, sig_model(4'h5, 9) ^ 4'b0100, 1'b0, -1);  // R7 mismatch fails
    run(4'h5, 9, sig_model(4'h5, 9), 1'b1, -1);            // R6 cleared on restart
    run(4'h0, 0, 4'h0, 1'b1, -1);                          // R3 zero count
    run(4'h9, 12, sig_model(4'h9, 12), 1'b1, 4);           // R2 start ignored when busy
    run(4'h0, 3, sig_model(4'h1, 3), 1'b1, -1);            // R5 zero seed as 0001

    func_in = 4'hC;  // R8 back to functional inputs after a run
    #1;
    check(cut_out == cut_model(4'hC), "R8 mux after run", cut_out, cut_model(4'hC));

    @(negedge clk);
    check(done == 1'b1 && pass == 1'b1, "R7 done holds", {done, pass}, 2'b11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule